// File: doc/BRIEF.md
# Burst-four separate-port SRAM

This block is a synthesizable memory with a read port and a write port that run independently of each other but share a single address bus. Every access moves a fixed burst of four words. A port starts a burst when its active-low select is seen low on a rising clock edge while that port is idle. The burst then occupies the port for two cycles, because each cycle carries two words. In silicon the two words would travel on the two clock phases. Here they travel as two parallel beats, and a 36-bit word is split into four 9-bit byte lanes.

Writes carry a per-byte, active-low enable for each beat. A lane whose enable is high keeps its stored contents. Reads return their four words on two parallel output beats, two cycles after the read is accepted. A valid flag stands in for the output driver enable. When no read burst is being delivered, the flag is low and both output buses read as zero. This models the tristated pins.

The storage is four banks, one per word position in the burst. The address selects one burst row across all four banks.

Top module: `burst4_sram`

## Requirements
- R1: While rst_n is low, rvalid is 0 and rdata0 and rdata1 are zero, and no burst is in progress on either port after reset is released.
- R2: With the write port idle, wr_sel_n low in cycle T with address A stores wdata0/wdata1 of cycle T as words 0/1 of row A, and wdata0/wdata1 of cycle T+1 as words 2/3 of row A.
- R3: wbe0_n qualifies the word on wdata0 and wbe1_n qualifies the word on wdata1 in the same cycle. A low bit k writes bits [9k+8:9k] of that word, and a high bit k leaves those stored bits unchanged.
- R4: With the read port idle, rd_sel_n low in cycle T with address A drives words 0/1 of row A on rdata0/rdata1 with rvalid high in cycle T+2, and words 2/3 in cycle T+3.
- R5: A select seen in the cycle after its port accepted a burst is ignored, together with the address in that cycle. A port whose select is high ignores the address, and on the write port also the data and byte enables, except for the second data cycle of an accepted write.
- R6: A read accepted in cycle T returns the data of every write burst accepted in cycle T-2 or earlier, and none of the data of a write accepted in T-1 or T. A read and a write to the same row in the same cycle therefore return the old contents.
- R7: rvalid is high only in the two output cycles of an accepted read. In every other cycle it is low and rdata0/rdata1 are zero, so it drops right after the last beat once the read port is deselected. Reads accepted every two cycles keep rvalid continuously high.
- R8: A port whose select is held low accepts one burst every two cycles, whatever the other port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the port sequencers |
| rd_sel_n | input | 1 | Active-low read-port select |
| wr_sel_n | input | 1 | Active-low write-port select |
| addr | input | AW (6) | Shared burst-row address |
| wdata0 | input | 36 | Write beat for words 0 and 2 |
| wdata1 | input | 36 | Write beat for words 1 and 3 |
| wbe0_n | input | 4 | Active-low byte enables for wdata0 |
| wbe1_n | input | 4 | Active-low byte enables for wdata1 |
| rdata0 | output | 36 | Read beat for words 0 and 2 |
| rdata1 | output | 36 | Read beat for words 1 and 3 |
| rvalid | output | 1 | High while a read beat is driven; low means outputs released |

## Verification
The bench first fills every row with continuous write selects, which shows that the second-cycle select and address are ignored and that bursts land in the right word positions. It then reads every row back with the read select held low, which separates a correct two-cycle latency and beat order from swapped or shifted beats and exposes any gap in rvalid. Masked writes with all-on, all-off and mixed byte enables separate lanes that are kept from lanes that are overwritten. Reads placed zero, one and two cycles after a write to the same row pin down the ordering rule. Long runs with both selects held low, and with random selects, then mix all of these against the reference model.

// File: rtl/b4s_pkg.sv
package b4s_pkg;
    localparam int BURST_WORDS     = 4;
    localparam int BEATS_PER_CYCLE = 2;
endpackage

// File: rtl/b4s_bank.sv
// One bank: holds one word position of every burst row, written per byte lane.
module b4s_bank #(
    parameter int AW     = 6,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [NBYTE*BYTE_W-1:0] wdata,
    input  logic [NBYTE-1:0]        wen,
    input  logic [AW-1:0]           raddr,
    output logic [NBYTE*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wen[b]) begin
                lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/b4s_wport.sv
// Write sequencer: first cycle buffers beats 0/1, second cycle commits all four.
module b4s_wport
    import b4s_pkg::*;
#(
    parameter int AW    = 6,
    parameter int W     = 36,
    parameter int NBYTE = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel_n,
    input  logic [AW-1:0]                     addr,
    input  logic [W-1:0]                      d0,
    input  logic [W-1:0]                      d1,
    input  logic [NBYTE-1:0]                  be0_n,
    input  logic [NBYTE-1:0]                  be1_n,
    output logic                              acc,
    output logic                              commit,
    output logic [AW-1:0]                     c_addr,
    output logic [BURST_WORDS-1:0][W-1:0]     c_data,
    output logic [BURST_WORDS-1:0][NBYTE-1:0] c_en
);
    typedef struct packed {
        logic             second;
        logic [AW-1:0]    addr;
        logic [W-1:0]     b0;
        logic [W-1:0]     b1;
        logic [NBYTE-1:0] e0;
        logic [NBYTE-1:0] e1;
    } wst_t;

    wst_t st_d, st_q;

    assign acc = !sel_n && !st_q.second;

    always_comb begin
        st_d        = st_q;
        st_d.second = acc;
        if (acc) begin
            st_d.addr = addr;
            st_d.b0   = d0;
            st_d.b1   = d1;
            st_d.e0   = ~be0_n;
            st_d.e1   = ~be1_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit = st_q.second;
    assign c_addr = st_q.addr;
    assign c_data = {d1, d0, st_q.b1, st_q.b0};
    assign c_en   = {~be1_n, ~be0_n, st_q.e1, st_q.e0};
endmodule

// File: rtl/b4s_rport.sv
// Read sequencer: captures the whole row on acceptance, then plays it out in two beats.
module b4s_rport
    import b4s_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 36
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_n,
    input  logic [AW-1:0]                 addr,
    input  logic [BURST_WORDS-1:0][W-1:0] row_q,
    output logic                          acc,
    output logic [AW-1:0]                 raddr,
    output logic                          rvalid,
    output logic [W-1:0]                  rdata0,
    output logic [W-1:0]                  rdata1
);
    typedef struct packed {
        logic [BURST_WORDS-1:0][W-1:0] cap;
        logic                          cap_v;
        logic                          hi_v;
        logic                          out_v;
        logic [W-1:0]                  out0;
        logic [W-1:0]                  out1;
    } rst_t;

    rst_t st_d, st_q;

    assign acc   = !sel_n && !st_q.cap_v;
    assign raddr = addr;

    always_comb begin
        st_d       = st_q;
        st_d.cap_v = acc;
        st_d.hi_v  = st_q.cap_v;
        if (acc) st_d.cap = row_q;
        if (st_q.cap_v) begin
            st_d.out_v = 1'b1;
            st_d.out0  = st_q.cap[0];
            st_d.out1  = st_q.cap[1];
        end else if (st_q.hi_v) begin
            st_d.out_v = 1'b1;
            st_d.out0  = st_q.cap[2];
            st_d.out1  = st_q.cap[3];
        end else begin
            st_d.out_v = 1'b0;
            st_d.out0  = '0;
            st_d.out1  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid = st_q.out_v;
    assign rdata0 = st_q.out0;
    assign rdata1 = st_q.out1;
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
    import b4s_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_sel_n,
    input  logic                    wr_sel_n,
    input  logic [AW-1:0]           addr,
    input  logic [NBYTE*BYTE_W-1:0] wdata0,
    input  logic [NBYTE*BYTE_W-1:0] wdata1,
    input  logic [NBYTE-1:0]        wbe0_n,
    input  logic [NBYTE-1:0]        wbe1_n,
    output logic [NBYTE*BYTE_W-1:0] rdata0,
    output logic [NBYTE*BYTE_W-1:0] rdata1,
    output logic                    rvalid
);
    localparam int W = NBYTE * BYTE_W;

    logic                              wr_acc, wr_commit, rd_acc;
    logic [AW-1:0]                     c_addr, raddr;
    logic [BURST_WORDS-1:0][W-1:0]     c_data, row_q;
    logic [BURST_WORDS-1:0][NBYTE-1:0] c_en;

    b4s_wport #(.AW(AW), .W(W), .NBYTE(NBYTE)) u_wport (
        .clk(clk), .rst_n(rst_n), .sel_n(wr_sel_n), .addr(addr),
        .d0(wdata0), .d1(wdata1), .be0_n(wbe0_n), .be1_n(wbe1_n),
        .acc(wr_acc), .commit(wr_commit), .c_addr(c_addr),
        .c_data(c_data), .c_en(c_en)
    );

    for (genvar k = 0; k < BURST_WORDS; k++) begin : g_bank
        b4s_bank #(.AW(AW), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_bank (
            .clk(clk), .we(wr_commit), .waddr(c_addr), .wdata(c_data[k]),
            .wen(c_en[k]), .raddr(raddr), .rdata(row_q[k])
        );
    end

    b4s_rport #(.AW(AW), .W(W)) u_rport (
        .clk(clk), .rst_n(rst_n), .sel_n(rd_sel_n), .addr(addr),
        .row_q(row_q), .acc(rd_acc), .raddr(raddr),
        .rvalid(rvalid), .rdata0(rdata0), .rdata1(rdata1)
    );
endmodule

// File: rtl/burst4_sram_chk.sv
module burst4_sram_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_acc,
    input logic         wr_acc,
    input logic         wr_commit,
    input logic         rvalid,
    input logic [W-1:0] rdata0,
    input logic [W-1:0] rdata1
);
    AST_WR_COMMITS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> wr_commit);                                           // R2
    AST_RD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> ##1 rvalid);                                          // R4
    AST_RD_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> ##2 rvalid);                                          // R4
    AST_RD_BUSY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> !rd_acc);                                             // R5
    AST_WR_BUSY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !wr_acc);                                          // R8
    AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(rd_acc, 2) || $past(rd_acc, 3)));              // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata0 == '0 && rdata1 == '0));                     // R7
endmodule

bind burst4_sram burst4_sram_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .wr_commit(wr_commit), .rvalid(rvalid), .rdata0(rdata0), .rdata1(rdata1)
);

// File: tb/burst4_sram_test.sv
`timescale 1ns/1ps
module burst4_sram_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_sel_n, wr_sel_n;
    logic [5:0]  addr;
    logic [35:0] wdata0, wdata1;
    logic [3:0]  wbe0_n, wbe1_n;
    logic [35:0] rdata0, rdata1;
    logic        rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    logic [35:0] rm [64][4];
    logic        mr_busy, mw_busy;
    logic [5:0]  mw_addr;
    logic [35:0] mw_b0, mw_b1;
    logic [3:0]  mw_m0, mw_m1;
    logic        fv [4];
    logic [35:0] f0 [4];
    logic [35:0] f1 [4];

    always #4 clk = ~clk;

    burst4_sram uut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata0(wdata0), .wdata1(wdata1), .wbe0_n(wbe0_n),
        .wbe1_n(wbe1_n), .rdata0(rdata0), .rdata1(rdata1), .rvalid(rvalid)
    );

    function automatic logic [35:0] rnd36();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[35:0];
    endfunction

    function automatic logic [35:0] mrg(input logic [35:0] old_w, input logic [35:0] new_w,
                                         input logic [3:0] m_n);
        logic [35:0] r;
        r = old_w;
        for (int k = 0; k < 4; k++) if (!m_n[k]) r[9*k +: 9] = new_w[9*k +: 9];
        return r;
    endfunction

    task automatic step(input logic rs, input logic ws, input logic [5:0] ad,
                        input logic [35:0] d0, input logic [35:0] d1,
                        input logic [3:0] m0, input logic [3:0] m1);
        logic [35:0] cw [4];
        logic racc, wacc;
        checks++;
        if (rvalid !== fv[0] || rdata0 !== f0[0] || rdata1 !== f1[0]) begin
            errors++;
            $display("FAIL %s (%s): rvalid=%b rdata0=%h rdata1=%h expected rvalid=%b rdata0=%h rdata1=%h",
                     fv[0] ? "R4" : "R7", tag, rvalid, rdata0, rdata1, fv[0], f0[0], f1[0]);
        end
        rd_sel_n = rs; wr_sel_n = ws; addr = ad;
        wdata0 = d0; wdata1 = d1; wbe0_n = m0; wbe1_n = m1;
        racc = !rs && !mr_busy;
        for (int k = 0; k < 4; k++) cw[k] = rm[ad][k];
        if (mw_busy) begin
            rm[mw_addr][0] = mrg(rm[mw_addr][0], mw_b0, mw_m0);
            rm[mw_addr][1] = mrg(rm[mw_addr][1], mw_b1, mw_m1);
            rm[mw_addr][2] = mrg(rm[mw_addr][2], d0, m0);
            rm[mw_addr][3] = mrg(rm[mw_addr][3], d1, m1);
        end
        wacc = !ws && !mw_busy;
        if (wacc) begin
            mw_addr = ad; mw_b0 = d0; mw_b1 = d1; mw_m0 = m0; mw_m1 = m1;
        end
        mr_busy = racc;
        mw_busy = wacc;
        if (racc) begin
            fv[2] = 1'b1; f0[2] = cw[0]; f1[2] = cw[1];
            fv[3] = 1'b1; f0[3] = cw[2]; f1[3] = cw[3];
        end
        for (int k = 0; k < 3; k++) begin
            fv[k] = fv[k+1]; f0[k] = f0[k+1]; f1[k] = f1[k+1];
        end
        fv[3] = 1'b0; f0[3] = '0; f1[3] = '0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 6'($urandom()), rnd36(), rnd36(), 4'($urandom()), 4'($urandom()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0;
        wdata0 = '0; wdata1 = '0; wbe0_n = '1; wbe1_n = '1;
        mr_busy = 0; mw_busy = 0; mw_addr = '0; mw_b0 = '0; mw_b1 = '0; mw_m0 = '1; mw_m1 = '1;
        for (int k = 0; k < 4; k++) begin fv[k] = 0; f0[k] = '0; f1[k] = '0; end
        for (int a = 0; a < 64; a++) for (int k = 0; k < 4; k++) rm[a][k] = '0;

        // R1: reset state, checked with selects low to show nothing starts
        repeat (3) begin
            @(negedge clk);
            rd_sel_n = 1'b0; wr_sel_n = 1'b0;
            checks++;
            if (rvalid !== 1'b0 || rdata0 !== '0 || rdata1 !== '0) begin
                errors++;
                $display("FAIL R1: rvalid=%b rdata0=%h rdata1=%h expected rvalid=0 rdata0=0 rdata1=0",
                         rvalid, rdata0, rdata1);
            end
        end
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R2 / R8: fill every row with the write select held low
        tag = "R2";
        for (int a = 0; a < 64; a++) begin
            step(1, 0, 6'(a), rnd36(), rnd36(), 4'h0, 4'h0);
            step(1, 0, 6'($urandom()), rnd36(), rnd36(), 4'h0, 4'h0);
        end
        idle(2);

        // R4 / R7: read every row back with the read select held low
        tag = "R4";
        for (int a = 0; a < 64; a++) begin
            step(0, 1, 6'(63 - a), rnd36(), rnd36(), 4'h0, 4'h0);
            step(0, 1, 6'($urandom()), rnd36(), rnd36(), 4'h0, 4'h0);
        end
        tag = "R7";
        idle(5);

        // R3: byte-enable patterns
        tag = "R3";
        for (int i = 0; i < 24; i++) begin
            logic [5:0] a;
            logic [3:0] m0, m1, m2, m3;
            a  = 6'($urandom());
            m0 = (i == 0) ? 4'hF : (i == 1) ? 4'h0 : 4'($urandom());
            m1 = (i == 0) ? 4'hF : 4'($urandom());
            m2 = (i == 2) ? 4'hF : 4'($urandom());
            m3 = (i == 3) ? 4'h0 : 4'($urandom());
            step(1, 0, a, rnd36(), rnd36(), m0, m1);
            step(1, 1, 6'($urandom()), rnd36(), rnd36(), m2, m3);
            step(0, 1, a, rnd36(), rnd36(), 4'h0, 4'h0);
            idle(3);
        end

        // R6: read placed in the same cycle, one and two cycles after a write
        tag = "R6";
        step(0, 0, 6'd5, rnd36(), rnd36(), 4'h0, 4'h0);
        step(1, 1, 6'd40, rnd36(), rnd36(), 4'h0, 4'h0);
        idle(4);
        step(0, 1, 6'd5, '0, '0, 4'h0, 4'h0);
        idle(4);
        step(1, 0, 6'd9, rnd36(), rnd36(), 4'h0, 4'h0);
        step(0, 1, 6'd9, rnd36(), rnd36(), 4'h0, 4'h0);
        idle(4);
        step(1, 0, 6'd13, rnd36(), rnd36(), 4'h0, 4'h0);
        step(1, 1, 6'd0, rnd36(), rnd36(), 4'h0, 4'h0);
        step(0, 1, 6'd13, rnd36(), rnd36(), 4'h0, 4'h0);
        idle(4);

        // R5: deselected ports and selects during the busy cycle
        tag = "R5";
        for (int i = 0; i < 10; i++) step(1, 1, 6'($urandom()), rnd36(), rnd36(), 4'h0, 4'h0);
        for (int i = 0; i < 10; i++) begin
            step(0, 0, 6'(i), rnd36(), rnd36(), 4'h0, 4'h0);
            step(0, 0, 6'(i + 20), rnd36(), rnd36(), 4'($urandom()), 4'($urandom()));
        end
        idle(3);
        for (int a = 0; a < 32; a++) begin
            step(0, 1, 6'(a), rnd36(), rnd36(), 4'h0, 4'h0);
            step(1, 1, 6'($urandom()), rnd36(), rnd36(), 4'h0, 4'h0);
        end
        idle(4);

        // R8: both selects held low with a new address every cycle
        tag = "R8";
        for (int i = 0; i < 300; i++)
            step(0, 0, 6'($urandom()), rnd36(), rnd36(), 4'($urandom()), 4'($urandom()));
        idle(4);

        // R7: random mix of everything
        tag = "R7";
        for (int i = 0; i < 3000; i++)
            step(1'($urandom()), 1'($urandom()), 6'($urandom()), rnd36(), rnd36(),
                 4'($urandom()), 4'($urandom()));
        idle(6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule